// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Detection

This block receives asynchronous serial frames on a single line. An external baud generator supplies a one-clock strobe sixteen times per bit; every piece of state advances only on that strobe. While enabled, the receiver looks for a start bit. It accepts a low sample as the first tick of a start bit only when the three samples before it were high. It then confirms the start at ticks 3, 5 and 7 and rejects it if the line has gone back high.

Once in sync, the receiver decides each bit by a majority of the samples at ticks 8, 9 and 10. It restarts its tick count on falling edges of the line, so small rate errors between sender and receiver do not add up. Any disagreement among the samples it looks at is remembered. That noise status is delivered with the received byte, together with a framing error for a low stop bit. The three flags stay set until the consumer pulses an acknowledge.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, and for as long as `rx_en_i` is low, `ready_o`, `noise_o`, `frame_err_o` and `data_o` keep their values (zero after reset). Frames on the line while the receiver is disabled produce nothing. Re-enabling clears the history, so three high ticks are needed before a start can be accepted.
- R2: In the hunt, a low tick is taken as tick 1 of a start bit only when the three preceding ticks were high. A low tick that follows at least one, but fewer than three, high ticks sets the internal noise flag and starts no frame.
- R3: A candidate start is abandoned when the ticks 3 and 5 are both high, or when at least two of the ticks 3, 5 and 7 are high. Abandoning sets the internal noise flag and needs three new high ticks before the next start.
- R4: A start that is accepted while the ticks 3, 5 and 7 disagree sets the internal noise flag. The byte is still received.
- R5: Each bit, including the start and stop bits, takes the majority of its ticks 8, 9 and 10. If these disagree, the internal noise flag is set. A falling edge seen at ticks 8 to 10 does not restart the count, and disturbances at other ticks cause no noise.
- R6: There are 8 data bits, least significant first, between one low start bit and one stop bit. `data_o` updates and `ready_o` rises on the clock edge that samples tick 10 of the stop bit.
- R7: Inside a frame, a falling edge at ticks 1 to 7 restarts the current bit at tick 1, and a falling edge at ticks 11 to 16 begins the next bit at tick 1. Alternating patterns are received correctly at bit lengths of 14 and 18 ticks.
- R8: A stop bit that votes low sets `frame_err_o` with the byte.
- R9: `noise_o` is raised together with `ready_o` when the internal noise flag was set at any point since the previous frame ended or the receiver was enabled. The internal noise flag is cleared when a frame completes and while disabled.
- R10: `ready_o`, `noise_o` and `frame_err_o` stay set until a one-clock `ack_i` clears them. `data_o` holds the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| ack_i | input | 1 | Read acknowledge, clears the flags |
| data_o | output | 8 | Last received byte |
| ready_o | output | 1 | Byte available |
| noise_o | output | 1 | Noise seen during the delivered frame |
| frame_err_o | output | 1 | Stop bit voted low |

## Verification
The bench sweeps every byte value and checks the exact tick at which the byte is delivered. A receiver with the wrong bit order, an off-by-one tick count or a late flag register fails here. It injects single-tick glitches at vote ticks, at the confirm ticks of the start bit, and outside the vote window. A design that votes on the wrong ticks, misses a disagreement or flags harmless glitches then reports the wrong noise or data. Short lone low pulses and lows preceded by only two highs must start no frame, and they must carry noise into the next good frame. Bit lengths of 14 and 18 ticks expose a receiver that does not re-align on edges or that re-aligns on the wrong bit.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
  localparam int OSR      = 16;
  localparam int CNT_W    = $clog2(OSR + 1);
  localparam int HIST_LEN = 3;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CONFIRM,
    ST_FRAME
  } rx_state_e;
endpackage

// File: rtl/osr_rx_vote.sv
module osr_rx_vote (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic bit_o,
  output logic split_o
);
  assign bit_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign split_o = (a_i | b_i | c_i) & ~(a_i & b_i & c_i);
endmodule

// File: rtl/osr_rx_hunt.sv
module osr_rx_hunt #(
  parameter int HIST_LEN = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_en_i,
  input  logic                load_en_i,
  input  logic [HIST_LEN-1:0] load_val_i,
  input  logic                rxd_i,
  output logic                start_o,
  output logic                false_o
);
  logic [HIST_LEN-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (load_en_i)  hist_q <= load_val_i;
    else if (shift_en_i) hist_q <= {hist_q[HIST_LEN-2:0], rxd_i};
  end

  assign start_o = shift_en_i & ~rxd_i & (&hist_q);
  assign false_o = shift_en_i & ~rxd_i & (|hist_q) & ~(&hist_q);

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i && !load_en_i |=> $stable(hist_q)); // R2
endmodule

// File: rtl/osr_rx_out.sv
module osr_rx_out #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 noise_i,
  input  logic                 ferr_i,
  input  logic                 ack_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 noise_o,
  output logic                 ferr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (load_i) begin
      data_o  <= data_i;
      ready_o <= 1'b1;
      noise_o <= noise_i;
      ferr_o  <= ferr_i;
    end else if (ack_i) begin
      ready_o <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
    end
  end

  AST_FLAG_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noise_o || ferr_o) |-> ready_o); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !load_i |=> !ready_o && !noise_o && !ferr_o); // R10
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o)); // R10
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_en_i,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  input  logic                 ack_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 noise_o,
  output logic                 frame_err_o
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [CNT_W-1:0] RT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RT_C1   = CNT_W'(3);
  localparam logic [CNT_W-1:0] RT_C2   = CNT_W'(5);
  localparam logic [CNT_W-1:0] RT_C3   = CNT_W'(7);
  localparam logic [CNT_W-1:0] RT_V1   = CNT_W'(8);
  localparam logic [CNT_W-1:0] RT_V2   = CNT_W'(9);
  localparam logic [CNT_W-1:0] RT_V3   = CNT_W'(10);
  localparam logic [CNT_W-1:0] RT_LAST = CNT_W'(OSR);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q, cnt_nxt;
  logic [IDX_W-1:0]     bit_idx_q;
  logic                 smp_a_q, smp_b_q;
  logic                 noise_q, prev_q;
  logic [DATA_BITS-1:0] shreg_q;

  logic vote, split;
  logic fall, in_win, restart, advance, is_data;
  logic act, reject, frame_done;
  logic hunt_start, hunt_false;

  osr_rx_vote u_vote (
    .a_i    (smp_a_q),
    .b_i    (smp_b_q),
    .c_i    (rxd_i),
    .bit_o  (vote),
    .split_o(split)
  );

  assign act     = rx_en_i & tick_i;
  assign cnt_nxt = (cnt_q == RT_LAST) ? RT_ONE : cnt_q + RT_ONE;
  assign fall    = prev_q & ~rxd_i;
  assign in_win  = (cnt_nxt >= RT_V1) && (cnt_nxt <= RT_V3);
  assign restart = fall && !in_win;
  // an edge after the vote window ends the current bit
  assign advance = (cnt_nxt == RT_ONE) || (restart && (cnt_nxt > RT_V3));
  assign is_data = (bit_idx_q != '0) && (bit_idx_q != LAST_IDX);

  assign reject = act && (state_q == ST_CONFIRM) &&
                  (((cnt_nxt == RT_C2) && smp_a_q && rxd_i) ||
                   ((cnt_nxt == RT_C3) && vote));
  assign frame_done = act && (state_q == ST_FRAME) &&
                      (bit_idx_q == LAST_IDX) && (cnt_nxt == RT_V3);

  osr_rx_hunt #(.HIST_LEN(HIST_LEN)) u_hunt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(act && (state_q == ST_HUNT)),
    .load_en_i (!rx_en_i || reject || frame_done),
    .load_val_i(frame_done ? {smp_a_q, smp_b_q, rxd_i} : '0),
    .rxd_i     (rxd_i),
    .start_o   (hunt_start),
    .false_o   (hunt_false)
  );

  osr_rx_out #(.DATA_BITS(DATA_BITS)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_done),
    .data_i (shreg_q),
    .noise_i(noise_q | split),
    .ferr_i (~vote),
    .ack_i  (ack_i),
    .data_o (data_o),
    .ready_o(ready_o),
    .noise_o(noise_o),
    .ferr_o (frame_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      cnt_q     <= '0;
      bit_idx_q <= '0;
      smp_a_q   <= 1'b0;
      smp_b_q   <= 1'b0;
      noise_q   <= 1'b0;
      prev_q    <= 1'b0;
      shreg_q   <= '0;
    end else if (!rx_en_i) begin
      state_q   <= ST_HUNT;
      cnt_q     <= '0;
      bit_idx_q <= '0;
      noise_q   <= 1'b0;
      prev_q    <= 1'b0;
    end else if (tick_i) begin
      prev_q <= rxd_i;
      unique case (state_q)
        ST_HUNT: begin
          if (hunt_start) begin
            state_q <= ST_CONFIRM;
            cnt_q   <= RT_ONE;
          end else if (hunt_false) begin
            noise_q <= 1'b1;
          end
        end
        ST_CONFIRM: begin
          cnt_q <= cnt_nxt;
          if (cnt_nxt == RT_C1) smp_a_q <= rxd_i;
          if (cnt_nxt == RT_C2) begin
            if (smp_a_q && rxd_i) begin
              noise_q <= 1'b1;
              state_q <= ST_HUNT;
            end else begin
              smp_b_q <= rxd_i;
            end
          end
          if (cnt_nxt == RT_C3) begin
            if (vote) begin
              noise_q <= 1'b1;
              state_q <= ST_HUNT;
            end else begin
              if (split) noise_q <= 1'b1;
              state_q   <= ST_FRAME;
              bit_idx_q <= '0;
            end
          end
        end
        ST_FRAME: begin
          cnt_q <= restart ? RT_ONE : cnt_nxt;
          if (advance) bit_idx_q <= bit_idx_q + IDX_ONE;
          if (cnt_nxt == RT_V1) smp_a_q <= rxd_i;
          if (cnt_nxt == RT_V2) smp_b_q <= rxd_i;
          if (cnt_nxt == RT_V3) begin
            if (split) noise_q <= 1'b1;
            if (is_data) shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
            if (bit_idx_q == LAST_IDX) begin
              state_q   <= ST_HUNT;
              noise_q   <= 1'b0;
              cnt_q     <= '0;
              bit_idx_q <= '0;
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  AST_CNT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_HUNT |-> (cnt_q >= RT_ONE) && (cnt_q <= RT_LAST)); // R7
  AST_IDX_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_q <= LAST_IDX); // R6
  AST_CONFIRM_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CONFIRM |-> cnt_q < RT_C3); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i && !ready_o |=> !ready_o); // R1
  AST_NOISE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !noise_q && state_q == ST_HUNT); // R9
endmodule

// File: tb/osr_uart_rx_tb_top.sv
module osr_uart_rx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       ack_i = 1'b0;
  logic [7:0] data_o;
  logic       ready_o, noise_o, frame_err_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  osr_uart_rx dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_en_i    (rx_en_i),
    .tick_i     (tick_i),
    .rxd_i      (rxd_i),
    .ack_i      (ack_i),
    .data_o     (data_o),
    .ready_o    (ready_o),
    .noise_o    (noise_o),
    .frame_err_o(frame_err_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_tick(input logic v);
    @(negedge clk_i);
    rxd_i  = v;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) do_tick(1'b1);
  endtask

  task automatic ack();
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  // gb/gp: bit index (0 start .. 9 stop) and tick position of a one-tick flip
  task automatic frame(input logic [7:0] b, input int blen, input logic stop_v,
                       input int gb, input int gp, input bit chk_t);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? stop_v : b[i-1];
      for (int p = 1; p <= blen; p++) begin
        logic x;
        x = (i == gb && p == gp) ? ~v : v;
        do_tick(x);
        if (chk_t && i == 9 && p == 9)  chk("R6 ready before stop tick 10", ready_o, 0);
        if (chk_t && i == 9 && p == 10) chk("R6 ready at stop tick 10", ready_o, 1);
      end
    end
    idle(4);
  endtask

  task automatic expect_frame(input string rq, input logic [7:0] d, input logic n,
                              input logic f, input bit hold);
    chk({rq, " ready"}, ready_o, 1);
    chk({rq, " data"}, data_o, d);
    chk({rq, " noise"}, noise_o, n);
    chk({rq, " frame_err"}, frame_err_o, f);
    if (hold) begin
      repeat (5) @(negedge clk_i);
      chk("R10 ready held", ready_o, 1);
      chk("R10 noise held", noise_o, n);
    end
    ack();
    chk("R10 ready cleared", ready_o, 0);
    chk("R10 noise cleared", noise_o, 0);
    chk("R10 frame_err cleared", frame_err_o, 0);
    chk("R10 data held", data_o, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset ready", ready_o, 0);
    chk("R1 reset noise", noise_o, 0);
    chk("R1 reset frame_err", frame_err_o, 0);
    chk("R1 reset data", data_o, 0);

    // R1: disabled receiver ignores a frame
    frame(8'hA5, 16, 1'b1, -1, 0, 0);
    chk("R1 disabled no ready", ready_o, 0);
    rx_en_i = 1'b1;
    idle(4);
    frame(8'hA5, 16, 1'b1, -1, 0, 0);
    expect_frame("R1 after enable", 8'hA5, 0, 0, 1);

    // R6: timing of delivery
    frame(8'hC3, 16, 1'b1, -1, 0, 1);
    expect_frame("R6 timed frame", 8'hC3, 0, 0, 0);

    // R2: low after only two highs is not a start
    rx_en_i = 1'b0;
    do_tick(1'b0);
    rx_en_i = 1'b1;
    do_tick(1'b0);
    do_tick(1'b0);
    do_tick(1'b1);
    do_tick(1'b1);
    frame(8'h00, 16, 1'b1, -1, 0, 0);
    idle(8);
    chk("R2 short history no frame", ready_o, 0);
    frame(8'h3C, 16, 1'b1, -1, 0, 0);
    expect_frame("R9 noise carried from hunt", 8'h3C, 1, 0, 0);
    frame(8'h3C, 16, 1'b1, -1, 0, 0);
    expect_frame("R9 noise cleared after frame", 8'h3C, 0, 0, 0);

    // R3: lone low tick rejected at tick 5
    do_tick(1'b0);
    idle(10);
    chk("R3 glitch no frame", ready_o, 0);
    frame(8'h81, 16, 1'b1, -1, 0, 0);
    expect_frame("R3 after tick5 reject", 8'h81, 1, 0, 0);
    // R3: four low ticks, rejected at tick 7
    for (int k = 0; k < 4; k++) do_tick(1'b0);
    idle(10);
    chk("R3 short low no frame", ready_o, 0);
    frame(8'h7E, 16, 1'b1, -1, 0, 0);
    expect_frame("R3 after tick7 reject", 8'h7E, 1, 0, 0);

    // R4: start accepted with tick 3 high
    frame(8'h96, 16, 1'b1, 0, 3, 0);
    expect_frame("R4 noisy start", 8'h96, 1, 0, 0);

    // R5: vote-window disagreements
    frame(8'h0F, 16, 1'b1, 2, 8, 0);
    expect_frame("R5 low flip tick 8", 8'h0F, 1, 0, 0);
    frame(8'h0F, 16, 1'b1, 6, 9, 0);
    expect_frame("R5 high flip tick 9", 8'h0F, 1, 0, 0);
    frame(8'h33, 16, 1'b1, 9, 10, 0);
    expect_frame("R5 stop flip tick 10", 8'h33, 1, 0, 0);
    frame(8'hFF, 16, 1'b1, 2, 4, 0);
    expect_frame("R5 flip outside window", 8'hFF, 0, 0, 0);

    // R7: rate mismatch
    frame(8'h55, 14, 1'b1, -1, 0, 0);
    expect_frame("R7 fast 55", 8'h55, 0, 0, 0);
    frame(8'hAA, 14, 1'b1, -1, 0, 0);
    expect_frame("R7 fast AA", 8'hAA, 0, 0, 0);
    frame(8'h55, 18, 1'b1, -1, 0, 0);
    expect_frame("R7 slow 55", 8'h55, 0, 0, 0);
    frame(8'hAA, 18, 1'b1, -1, 0, 0);
    expect_frame("R7 slow AA", 8'hAA, 0, 0, 0);

    // R8: low stop bit
    frame(8'h5A, 16, 1'b0, -1, 0, 0);
    expect_frame("R8 framing error", 8'h5A, 0, 1, 0);
    frame(8'h5A, 16, 1'b1, -1, 0, 0);
    expect_frame("R8 clean after error", 8'h5A, 0, 0, 0);

    // R6: every byte value
    for (int b = 0; b < 256; b++) begin
      frame(8'(b), 16, 1'b1, -1, 0, 0);
      chk("R6 sweep ready", ready_o, 1);
      chk("R6 sweep data", data_o, 32'(b));
      chk("R6 sweep noise", noise_o, 0);
      chk("R6 sweep frame_err", frame_err_o, 0);
      ack();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule